// File: doc/BRIEF.md
# Small-Core Interrupt Controller with Fixed Vectors

This block gathers the interrupt sources of a small 8-bit core and decides which one the core takes next. There are four sources. The first is an external pin whose trigger mode is programmable. The other three are single-cycle event pulses: a pin change, a timer overflow and a comparator event. The block holds a latched flag per source, an enable mask and a global enable bit. When an enabled, pending source exists and the global enable is one, it raises a request and presents a fixed vector number to the core.

The core signals an acknowledge in the cycle it enters a vector. The block then clears the global enable and the flag that belongs to the presented vector. A return-from-interrupt strobe sets the global enable again. Software reaches the mask, flags, sense mode and global enable through a small 2-bit-select register port. Flags are cleared by writing ones to the flag register.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the mask, flag, sense and global-enable registers all read 0 and `irq_req_o` is 0.
- R2: `irq_req_o` is 1 only when the global enable is 1 and at least one source is both pending and enabled in the mask.
- R3: The vector equals the source index plus one: 1 for the external pin, 2 for pin change, 3 for timer overflow and 4 for comparator. Vector 0 stays reserved for reset. `irq_vec_o` is 0 whenever no request is raised.
- R4: When several enabled sources are pending, the lowest vector number is presented.
- R5: An acknowledge while a request is raised clears the global enable. It also clears the flag of the presented vector and leaves every other flag unchanged.
- R6: A return-from-interrupt strobe sets the global enable. An acknowledge in the same cycle takes precedence.
- R7: Writing the flag register clears each flag whose data bit is one. A zero bit has no effect. A source event in the same cycle as a write clear leaves that flag set.
- R8: An event pulse on `evt_i[k]` sets flag bit k+1 on the next clock edge, whatever the mask holds.
- R9: The sense field (select 2, bits 1:0) chooses the external-pin trigger: 01 any change, 10 falling edge, 11 rising edge. Through its two-flop synchroniser, a qualifying pin change shows as flag bit 0 three clock edges after it is applied.
- R10: With sense 00 the external source is level-sensitive. It is pending while the synchronised pin is low, it latches no flag, and an acknowledge does not remove it.
- R11: Register map by `reg_sel_i`: 0 mask (bit i = source i), 1 flags (same bit order), 2 sense (bits 1:0), 3 global enable (bit 0). Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| evt_i | input | EVT_N | Event pulses: bit0 pin change, bit1 timer overflow, bit2 comparator |
| reg_sel_i | input | 2 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on select) |
| irq_ack_i | input | 1 | Core enters the presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | VEC_W | Vector number of the winning source |

## Verification
The bench builds the block with its default of three event sources. This gives four sources in total, a 3-bit vector and the idle-high pin reset value. With that setting every vector from 1 to 4 can be reached, along with all three-way and four-way priority contests. The reserved upper four bits of the mask and flag registers can also be observed. Directed sequences walk each sense mode through the synchroniser latency. Random mask, event and enable patterns then exercise the priority encoder against a bench-side model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_FLAG  = 2'd1,
    SEL_SENSE = 2'd2,
    SEL_GIE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
  import irq_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   edge_o,
  output logic   low_o
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       pin_s, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
    end
  end

  assign pin_s = sync_q[1];
  assign rise  = pin_s & ~prev_q;
  assign fall  = ~pin_s & prev_q;
  assign low_o = ~pin_s;

  always_comb begin
    unique case (mode_i)
      SNS_ANY:  edge_o = rise | fall;
      SNS_FALL: edge_o = fall;
      SNS_RISE: edge_o = rise;
      default:  edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // set beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 4,
  parameter int VEC_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VEC_W'(i + 1);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter  int   EVT_N    = 3,
  parameter  logic PIN_IDLE = 1'b1,
  localparam int   NUM_SRC  = EVT_N + 1,
  localparam int   VEC_W    = $clog2(NUM_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_pin_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             irq_ack_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic [NUM_SRC-1:0] mask_q, flag_q, pend, cand, set_v, clr_v, ack_clr;
  sense_e             sense_q;
  logic               gie_q;
  logic               ext_edge, ext_low, any_c, take;
  logic [VEC_W-1:0]   win_vec;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_pin_sense #(.RST_VAL(PIN_IDLE)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .mode_i (sense_q),
    .edge_o (ext_edge),
    .low_o  (ext_low)
  );

  assign set_v = {evt_i, ext_edge};
  assign take  = irq_ack_i & irq_req_o;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ack_clr[i] = take & (win_vec == VEC_W'(i + 1));
  end

  assign clr_v = ack_clr |
                 ((reg_we_i && sel == SEL_FLAG) ? reg_wdata_i[NUM_SRC-1:0] : '0);

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_q)
  );

  assign pend = {flag_q[NUM_SRC-1:1], (sense_q == SNS_LOW) ? ext_low : flag_q[0]};
  assign cand = pend & mask_q;

  irq_prio #(.N(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .req_i (cand),
    .any_o (any_c),
    .vec_o (win_vec)
  );

  assign irq_req_o = gie_q & any_c;
  assign irq_vec_o = irq_req_o ? win_vec : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      sense_q <= SNS_LOW;
      gie_q   <= 1'b0;
    end else begin
      if (reg_we_i && sel == SEL_MASK)  mask_q  <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_we_i && sel == SEL_SENSE) sense_q <= sense_e'(reg_wdata_i[1:0]);
      if (take)                          gie_q <= 1'b0;
      else if (reti_i)                   gie_q <= 1'b1;
      else if (reg_we_i && sel == SEL_GIE) gie_q <= reg_wdata_i[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MASK:  reg_rdata_o = {{PAD_W{1'b0}}, mask_q};
      SEL_FLAG:  reg_rdata_o = {{PAD_W{1'b0}}, flag_q};
      SEL_SENSE: reg_rdata_o = {6'b0, sense_q};
      default:   reg_rdata_o = {7'b0, gie_q};
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int EVT_N   = 3,
  parameter int NUM_SRC = EVT_N + 1,
  parameter int VEC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [EVT_N-1:0]   evt_i,
  input logic               irq_ack_i,
  input logic               reti_i,
  input logic               irq_req_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic               gie_q,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] cand
);
  logic [NUM_SRC-1:0] below;
  always_comb begin
    below = '0;
    for (int i = 0; i < NUM_SRC; i++) below[i] = (VEC_W'(i + 1) < irq_vec_o);
  end

  assert_req_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (gie_q && (|cand)));

  assert_vec_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o != '0 && irq_vec_o <= VEC_W'(NUM_SRC)));

  assert_vec_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_vec_o == '0));

  assert_lowest_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((cand & below) == '0));

  assert_ack_drops_gie_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> !gie_q);

  assert_reti_sets_gie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(irq_ack_i && irq_req_o)) |=> gie_q);

  assert_evt_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q[NUM_SRC-1:1] & $past(evt_i)) == $past(evt_i)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.EVT_N(EVT_N), .NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .irq_ack_i (irq_ack_i),
  .reti_i    (reti_i),
  .irq_req_o (irq_req_o),
  .irq_vec_o (irq_vec_o),
  .gie_q     (gie_q),
  .flag_q    (flag_q),
  .cand      (cand)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic [2:0] evt = '0;
  logic [1:0] sel = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       req;
  logic [2:0] vec;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(pin), .evt_i(evt),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .reti_i(reti), .irq_req_o(req), .irq_vec_o(vec)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    sel = s; #1; d = rdata;
  endtask

  task automatic pulse(logic [2:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_vec(logic [3:0] c, logic g);
    if (!g) return 8'd0;
    for (int i = 0; i < 4; i++) if (c[i]) return 8'(i + 1);
    return 8'd0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    wait_n(3); rst_n = 1'b1; wait_n(1);

    for (int s = 0; s < 4; s++) begin rd(2'(s), d); check("R1 reg reset", d, 8'h00); end
    check("R1 req reset", {7'b0, req}, 8'h00);

    wr(0, 8'hFF); rd(0, d); check("R11 mask reserved", d, 8'h0F);
    wr(2, 8'hFF); rd(2, d); check("R11 sense reserved", d, 8'h03);
    wr(3, 8'hFF); rd(3, d); check("R11 gie reserved", d, 8'h01);
    wr(3, 8'h00); wr(0, 8'h00);  // sense stays rising

    pulse(3'b111); rd(1, d); check("R8 flags without mask", d, 8'h0E);
    check("R2 no req masked", {7'b0, req}, 8'h00);
    wr(0, 8'h0E); check("R2 no req gie off", {7'b0, req}, 8'h00);
    wr(3, 8'h01);
    check("R4 pc wins", {5'b0, vec}, 8'd2);
    check("R2 req on", {7'b0, req}, 8'h01);

    do_ack(); rd(1, d); check("R5 flag of vec2 cleared", d, 8'h0C);
    rd(3, d); check("R5 gie cleared", d, 8'h00);
    check("R5 req dropped", {7'b0, req}, 8'h00);
    do_reti(); rd(3, d); check("R6 gie set", d, 8'h01);
    check("R3 timer vec", {5'b0, vec}, 8'd3);
    do_ack(); do_reti(); check("R3 comparator vec", {5'b0, vec}, 8'd4);
    do_ack(); do_reti(); check("R2 idle after all", {7'b0, req}, 8'h00);
    rd(1, d); check("R5 all flags gone", d, 8'h00);

    // ack and reti together: ack wins
    pulse(3'b010);
    @(negedge clk); ack = 1'b1; reti = 1'b1;
    @(negedge clk); ack = 1'b0; reti = 1'b0;
    rd(3, d); check("R6 ack beats reti", d, 8'h00);

    wr(3, 8'h00);
    pulse(3'b110); wr(1, 8'h04); rd(1, d); check("R7 write one clears", d, 8'h08);
    wr(1, 8'h00); rd(1, d); check("R7 zero no effect", d, 8'h08);
    @(negedge clk); evt = 3'b010; sel = 1; wdata = 8'h0C; we = 1'b1;
    @(negedge clk); evt = '0; we = 1'b0;
    rd(1, d); check("R7 set beats clear", d, 8'h04);
    wr(1, 8'hFF);

    // external edge modes
    wr(0, 8'h01); wr(2, 8'h03);
    @(negedge clk); pin = 1'b0; wait_n(3);
    rd(1, d); check("R9 fall ignored in rise mode", d, 8'h00);
    pin = 1'b1; wait_n(2);
    rd(1, d); check("R9 not yet after 2 edges", d, 8'h00);
    wait_n(1); rd(1, d); check("R9 rise flag at 3 edges", d, 8'h01);
    wr(3, 8'h01); check("R3 ext vec", {5'b0, vec}, 8'd1);
    do_ack(); rd(1, d); check("R5 ext flag cleared", d, 8'h00);
    wr(2, 8'h02);
    @(negedge clk); pin = 1'b0; wait_n(3);
    rd(1, d); check("R9 falling mode", d, 8'h01);
    wr(1, 8'h01);
    @(negedge clk); pin = 1'b1; wait_n(3);
    rd(1, d); check("R9 rise ignored in fall mode", d, 8'h00);
    wr(2, 8'h01);
    @(negedge clk); pin = 1'b0; wait_n(3);
    rd(1, d); check("R9 any change fall", d, 8'h01);
    wr(1, 8'h01);
    @(negedge clk); pin = 1'b1; wait_n(3);
    rd(1, d); check("R9 any change rise", d, 8'h01);
    wr(1, 8'h01);

    // level mode
    wr(2, 8'h00); wr(0, 8'h03); wr(3, 8'h01);
    pulse(3'b001);
    check("R4 pc alone", {5'b0, vec}, 8'd2);
    @(negedge clk); pin = 1'b0; wait_n(2);
    check("R10 level pending", {7'b0, req}, 8'h01);
    check("R4 level beats pc", {5'b0, vec}, 8'd1);
    rd(1, d); check("R10 no latched flag", d, 8'h02);
    do_ack(); do_reti();
    check("R10 still pending after ack", {5'b0, vec}, 8'd1);
    @(negedge clk); pin = 1'b1; wait_n(2);
    check("R10 released", {5'b0, vec}, 8'd2);
    wr(1, 8'hFF);
    wr(2, 8'h03);

    for (int it = 0; it < 60; it++) begin
      logic [3:0] m;
      logic [2:0] e;
      logic       g;
      wr(3, 8'h00); wr(1, 8'hFF);
      m = 4'($urandom) & 4'hE; e = 3'($urandom); g = 1'($urandom);
      wr(0, {4'b0, m}); pulse(e); wr(3, {7'b0, g});
      check("R4 random vec", {5'b0, vec}, exp_vec({e, 1'b0} & m, g));
      check("R2 random req", {7'b0, req}, {7'b0, (exp_vec({e, 1'b0} & m, g) != 0)});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule